// File: doc/BRIEF.md
# Byte-serial AES-128 core

This block is an area-minimal AES-128 engine for a passively powered tag. Each byte of work passes through an 8-bit datapath. One shared substitution unit serves SubBytes, InvSubBytes and the key schedule. A quarter-column mixing unit produces one MixColumns or InvMixColumns output byte per operation. The 128-bit block and the 128-bit key sit together in a 32x8 register store. Round keys are derived in place, one round at a time, so no expanded schedule is ever stored.

The host writes 16 block bytes and then 16 key bytes through a byte port, one byte per write strobe. It then pulses start with the direction select held at the wanted value. For decryption the host loads the ordinary cipher key. The core first walks the key schedule forward to the last round key and then runs it backwards while it deciphers. When the core finishes, it raises a flag and holds it. The result is read one byte per read strobe.

ShiftRows and its inverse move no bytes. A per-row rotation offset is updated instead, and every state access and the final readout are steered through that offset.

Top module: `tag_aes_core`

## Requirements
- R1: With enc_i high at start, the 16 bytes read out equal the AES-128 encryption of the loaded block under the loaded key. Byte n of any block or key is row n mod 4, column n/4, which is the n-th byte of the standard hexadecimal string.
- R2: With enc_i low at start, the 16 bytes read out equal the AES-128 decryption of the loaded block under the loaded cipher key (not the last round key).
- R3: Each cycle with wr_i high and the core not busy stores data_i. The 1st to 16th such bytes after a start (or after reset) form the block, and the 17th to 32nd form the key.
- R4: done_o rises exactly 640 clock edges after the edge that accepts start for encryption, and exactly 800 edges after it for decryption.
- R5: done_o stays high until a start is accepted, and it is low in the cycle after the accepting edge.
- R6: While done_o is high, data_o shows result byte n, where n is the number of rd_i strobes seen since done_o rose. With no strobe, data_o holds its byte.
- R7: While the core is busy, wr_i and start_i have no effect: the latency and the result are unchanged.
- R8: After reset, done_o is low and data_o is zero.
- R9: data_o is zero whenever done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Byte write strobe for loading block and key |
| data_i | input | 8 | Byte to load |
| start_i | input | 1 | Begins processing when the core is not busy |
| enc_i | input | 1 | 1 = encrypt, 0 = decrypt; sampled with start |
| rd_i | input | 1 | Advances the readout to the next result byte |
| data_o | output | 8 | Current result byte while done, else zero |
| done_o | output | 1 | Result ready; held until the next start |

## Verification
The store has a single write port, shared by host loading and the round sequencer. A host write strobe can therefore land in the same cycle as a datapath write, and a stray start can land in the middle of a round. The bench provokes both in one run: a hundred cycles after start it pulses wr_i with a junk byte and start_i with the opposite direction. It then requires that the latency still matches the exact count for the original direction and that every result byte still matches the known-answer vector.

// File: rtl/tag_aes_pkg.sv
package tag_aes_pkg;

  localparam int BYTE_W    = 8;
  localparam int BLK_BYTES = 16;
  localparam int MEM_DEPTH = 2 * BLK_BYTES;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int IDX_W     = $clog2(BLK_BYTES);
  localparam int STEP_W    = $clog2(2 * BLK_BYTES);
  localparam int ROUNDS    = 10;
  localparam int RND_W     = $clog2(ROUNDS + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_KEY, PH_SUB, PH_MIX, PH_ARK, PH_DONE
  } phase_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] inv_xtime(input logic [7:0] a);
    return a[0] ? ({1'b0, a[7:1] ^ 7'h0d} | 8'h80) : {1'b0, a[7:1]};
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // x^254 by repeated squaring; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r = 8'h01;
    logic [7:0] p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] fwd_affine(input logic [7:0] a);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
    return y ^ 8'h63;
  endfunction

  function automatic logic [7:0] rev_affine(input logic [7:0] a);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8];
    return y ^ 8'h05;
  endfunction

endpackage

// File: rtl/tag_aes_mem.sv
module tag_aes_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_a_i,
  output logic [W-1:0]  rd_a_o,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_b_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  assign rd_a_o = mem_q[ra_a_i];
  assign rd_b_o = mem_q[ra_b_i];

endmodule

// File: rtl/tag_aes_sbox.sv
module tag_aes_sbox import tag_aes_pkg::*; (
  input  logic [BYTE_W-1:0] x_i,
  input  logic              inv_i,
  output logic [BYTE_W-1:0] y_o
);

  logic [BYTE_W-1:0] pre, g;

  // one field inverter serves both directions
  always_comb begin
    pre = inv_i ? rev_affine(x_i) : x_i;
    g   = gf_inv(pre);
    y_o = inv_i ? g : fwd_affine(g);
  end

endmodule

// File: rtl/tag_aes_mixq.sv
module tag_aes_mixq import tag_aes_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [1:0]        ld_row_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  input  logic [1:0]        row_i,
  input  logic              inv_i,
  output logic [BYTE_W-1:0] out_o
);

  logic [BYTE_W-1:0] col_q [4];
  logic [1:0]        i1, i2, i3;
  logic [BYTE_W-1:0] a0, a1, a2, a3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) col_q[i] <= '0;
    end else if (ld_i) begin
      col_q[ld_row_i] <= ld_data_i;
    end
  end

  always_comb begin
    i1 = row_i + 2'd1;
    i2 = row_i + 2'd2;
    i3 = row_i + 2'd3;
    a0 = col_q[row_i];
    a1 = col_q[i1];
    a2 = col_q[i2];
    a3 = col_q[i3];
    if (inv_i)
      out_o = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
    else
      out_o = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
  end

endmodule

// File: rtl/tag_aes_seq.sv
module tag_aes_seq import tag_aes_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enc_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o,
  output logic              dec_o,
  output logic              key_fwd_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);

  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [RND_W-1:0]  rnd_q;
  logic              dec_q, kx_q;

  assign busy_o    = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign done_o    = (phase_q == PH_DONE);
  assign last_o    = busy_o && ((phase_q == PH_MIX) ? (step_q == STEP_W'(2*BLK_BYTES-1))
                                                    : (step_q == STEP_W'(BLK_BYTES-1)));
  assign key_fwd_o = !dec_q || kx_q;
  assign phase_o   = phase_q;
  assign step_o    = step_q;
  assign dec_o     = dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rnd_q   <= '0;
      dec_q   <= 1'b0;
      kx_q    <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        dec_q  <= !enc_i;
        step_q <= '0;
        if (enc_i) begin
          phase_q <= PH_ARK;
          rnd_q   <= '0;
          kx_q    <= 1'b0;
        end else begin
          phase_q <= PH_KEY;
          rnd_q   <= RND_W'(1);
          kx_q    <= 1'b1;
        end
      end
    end else begin
      step_q <= last_o ? '0 : STEP_W'(step_q + 1'b1);
      if (last_o) begin
        unique case (phase_q)
          PH_KEY: begin
            if (kx_q) begin
              // forward walk to the last round key before deciphering
              if (rnd_q == RND_W'(ROUNDS)) begin
                kx_q    <= 1'b0;
                phase_q <= PH_ARK;
              end else begin
                rnd_q <= RND_W'(rnd_q + 1'b1);
              end
            end else if (!dec_q) begin
              phase_q <= PH_SUB;
            end else begin
              phase_q <= (rnd_q == '0) ? PH_ARK : PH_MIX;
            end
          end
          PH_SUB: begin
            if (dec_q) phase_q <= PH_KEY;
            else       phase_q <= (rnd_q == RND_W'(ROUNDS)) ? PH_ARK : PH_MIX;
          end
          PH_MIX: begin
            if (dec_q) begin
              rnd_q   <= RND_W'(rnd_q - 1'b1);
              phase_q <= PH_SUB;
            end else begin
              rnd_q   <= RND_W'(rnd_q + 1'b1);
              phase_q <= PH_KEY;
            end
          end
          PH_ARK: begin
            if (!dec_q && rnd_q == '0) begin
              rnd_q   <= RND_W'(1);
              phase_q <= PH_KEY;
            end else if (dec_q && rnd_q == RND_W'(ROUNDS)) begin
              rnd_q   <= RND_W'(ROUNDS - 1);
              phase_q <= PH_SUB;
            end else begin
              phase_q <= PH_DONE;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assert_done_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o);

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_done_after_work_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_round_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_q <= RND_W'(ROUNDS));

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(dec_q));

endmodule

// File: rtl/tag_aes_core.sv
module tag_aes_core import tag_aes_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              start_i,
  input  logic              enc_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              done_o
);

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic              dec, key_fwd, last, busy, done;

  logic              we;
  logic [MEM_AW-1:0] wa, ra, rb;
  logic [BYTE_W-1:0] wd, rda, rdb;
  logic [BYTE_W-1:0] sb_in, sb_out, mx_ld_data, mx_out;
  logic              sb_inv, mx_ld;
  logic [1:0]        mx_ld_row, mx_row;

  logic [1:0]        off_q [4];
  logic [BYTE_W-1:0] rc_q, rc_use;
  logic [MEM_AW-1:0] wr_ptr_q;
  logic [IDX_W-1:0]  rd_ptr_q;

  logic start_ok, sub_end, key_end;

  assign start_ok = start_i && !busy;
  assign sub_end  = (phase == PH_SUB) && last;
  assign key_end  = (phase == PH_KEY) && last;
  assign rc_use   = key_fwd ? rc_q : inv_xtime(rc_q);

  // logical (row, col) to physical state slot under row rotation
  function automatic logic [IDX_W-1:0] phys(input logic [1:0] r, input logic [1:0] c,
                                            input logic [1:0] o);
    return {c + o, r};
  endfunction

  tag_aes_seq u_seq (
    .clk_i, .rst_ni, .start_i, .enc_i,
    .phase_o(phase), .step_o(step), .dec_o(dec), .key_fwd_o(key_fwd),
    .last_o(last), .busy_o(busy), .done_o(done)
  );

  tag_aes_mem #(.W(BYTE_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk_i, .we_i(we), .wa_i(wa), .wd_i(wd),
    .ra_a_i(ra), .rd_a_o(rda), .ra_b_i(rb), .rd_b_o(rdb)
  );

  tag_aes_sbox u_sbox (.x_i(sb_in), .inv_i(sb_inv), .y_o(sb_out));

  tag_aes_mixq u_mixq (
    .clk_i, .rst_ni, .ld_i(mx_ld), .ld_row_i(mx_ld_row), .ld_data_i(mx_ld_data),
    .row_i(mx_row), .inv_i(dec), .out_o(mx_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < 4; r++) off_q[r] <= '0;
      rc_q     <= 8'h01;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (start_ok) begin
        for (int r = 0; r < 4; r++) off_q[r] <= '0;
        rc_q     <= 8'h01;
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (sub_end) begin
          for (int r = 0; r < 4; r++)
            off_q[r] <= dec ? off_q[r] - 2'(r) : off_q[r] + 2'(r);
        end
        if (key_end) rc_q <= key_fwd ? xtime(rc_q) : rc_use;
        if (!busy && wr_i) wr_ptr_q <= MEM_AW'(wr_ptr_q + 1'b1);
        if (done && rd_i)  rd_ptr_q <= IDX_W'(rd_ptr_q + 1'b1);
      end
    end
  end

  always_comb begin
    logic [1:0] lr, lc, kc, mr, mc, nr;
    lr = step[1:0];
    lc = step[3:2];
    mr = step[1:0];
    mc = step[4:3];
    kc = key_fwd ? lc : ~lc;
    nr = lr + 2'd1;

    ra         = '0;
    rb         = '0;
    we         = 1'b0;
    wa         = '0;
    wd         = '0;
    sb_in      = rdb;
    sb_inv     = 1'b0;
    mx_ld      = 1'b0;
    mx_ld_row  = mr;
    mx_ld_data = rda;
    mx_row     = mr;

    unique case (phase)
      PH_ARK: begin
        ra = {1'b0, phys(lr, lc, off_q[lr])};
        rb = {1'b1, lc, lr};
        we = 1'b1;
        wa = ra;
        wd = rda ^ rdb;
      end
      PH_SUB: begin
        ra     = {1'b0, step[IDX_W-1:0]};
        sb_in  = rda;
        sb_inv = dec;
        we     = 1'b1;
        wa     = ra;
        wd     = sb_out;
      end
      PH_KEY: begin
        ra = {1'b1, kc, lr};
        we = 1'b1;
        wa = ra;
        if (kc == 2'd0) begin
          rb = {1'b1, 2'd3, nr};
          wd = rda ^ sb_out ^ ((lr == 2'd0) ? rc_use : 8'h00);
        end else begin
          rb = {1'b1, kc - 2'd1, lr};
          wd = rda ^ rdb;
        end
      end
      PH_MIX: begin
        rb = {1'b1, mc, mr};
        if (!step[2]) begin
          ra         = {1'b0, phys(mr, mc, off_q[mr])};
          mx_ld      = 1'b1;
          mx_ld_data = dec ? (rda ^ rdb) : rda;
        end else begin
          we = 1'b1;
          wa = {1'b0, phys(mr, mc, off_q[mr])};
          wd = dec ? mx_out : (mx_out ^ rdb);
        end
      end
      default: begin
        ra = {1'b0, phys(rd_ptr_q[1:0], rd_ptr_q[3:2], off_q[rd_ptr_q[1:0]])};
        we = wr_i;
        wa = wr_ptr_q;
        wd = data_i;
      end
    endcase
  end

  assign data_o = done ? rda : '0;
  assign done_o = done;

  assert_wr_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_i) |=> (wr_ptr_q == $past(wr_ptr_q)));

  assert_dout_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> (data_o == '0));

endmodule

// File: tb/tag_aes_core_tb_top.sv
`timescale 1ns/1ps
module tag_aes_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, start_i = 1'b0, enc_i = 1'b1, rd_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       done_o;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  tag_aes_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .data_i(data_i), .start_i(start_i),
    .enc_i(enc_i), .rd_i(rd_i), .data_o(data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected byte per read strobe
  always @(negedge clk) begin
    if (rd_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected read", {24'd0, data_o}, 32'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(data_o === e && done_o, t, {24'd0, data_o}, {24'd0, e});
      end
    end
  end

  task automatic load(input logic [127:0] blk, input logic [127:0] key);
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      wr_i   = 1'b1;
      data_i = (i < 16) ? blk[127-8*i -: 8] : key[127-8*(i-16) -: 8];
    end
    @(posedge clk); #1;
    wr_i = 1'b0;
  endtask

  task automatic run(input bit enc, input int exp_lat, input bit noise);
    int lat;
    @(posedge clk); #1;
    start_i = 1'b1;
    enc_i   = enc;
    @(posedge clk); #1;
    start_i = 1'b0;
    chk(!done_o, "R5 done low after start", {31'd0, done_o}, 32'd0);
    lat = 0;
    while (!done_o && lat < 3000) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 50) chk(data_o == 8'h00, "R9 data_o quiet while busy", {24'd0, data_o}, 32'd0);
      if (noise && lat == 100) begin
        wr_i = 1'b1; data_i = 8'hff; start_i = 1'b1; enc_i = !enc;
      end
      if (noise && lat == 101) begin
        wr_i = 1'b0; start_i = 1'b0; enc_i = enc;
      end
    end
    chk(lat == exp_lat, noise ? "R7 latency under stray strobes" : "R4 latency", lat, exp_lat);
  endtask

  task automatic read_out(input logic [127:0] exp, input string tag);
    repeat (3) @(posedge clk);
    #1;
    chk(data_o == exp[127 -: 8], "R6 first byte held", {24'd0, data_o}, {24'd0, exp[127 -: 8]});
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(exp[127-8*i -: 8]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      rd_i = 1'b1;
    end
    @(posedge clk); #1;
    rd_i = 1'b0;
    chk(exp_q.size() == 0, "R6 all bytes consumed", exp_q.size(), 0);
    chk(done_o, "R5 done held after readout", {31'd0, done_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] k1, p1, c1, k2, p2, c2, z, cz;
    k1 = 128'h000102030405060708090a0b0c0d0e0f;
    p1 = 128'h00112233445566778899aabbccddeeff;
    c1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    k2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p2 = 128'h3243f6a8885a308d313198a2e0370734;
    c2 = 128'h3925841d02dc09fbdc118597196a0b32;
    z  = '0;
    cz = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    repeat (3) @(posedge clk);
    #1;
    chk(!done_o, "R8 done after reset", {31'd0, done_o}, 32'd0);
    chk(data_o == 8'h00, "R8 data_o after reset", {24'd0, data_o}, 32'd0);
    rst_ni = 1'b1;

    // R1 R3 R7: encryption with stray write and start mid-run
    load(p1, k1);
    run(1'b1, 640, 1'b1);
    read_out(c1, "R1 encrypt vector A");

    // R2: decrypt back with the cipher key
    load(c1, k1);
    run(1'b0, 800, 1'b0);
    read_out(p1, "R2 decrypt vector A");

    load(p2, k2);
    run(1'b1, 640, 1'b0);
    read_out(c2, "R1 encrypt vector B");

    load(c2, k2);
    run(1'b0, 800, 1'b1);
    read_out(p2, "R2 decrypt vector B");

    load(z, z);
    run(1'b1, 640, 1'b0);
    read_out(cz, "R1 encrypt zero vector");

    load(cz, z);
    run(1'b0, 800, 1'b0);
    read_out(z, "R2 decrypt zero vector");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule